// File: doc/BRIEF.md
# Loadable Two-Digit BCD Up/Down Counter (0 to 63)

This block holds a two-digit decimal value, kept as a tens digit and a units digit in BCD, that spans 00 to 63. A free-running prescaler on the main clock produces a step strobe once in every eight clocks. While `start` is high, each strobe moves the value one step up or down, as `count_up` selects. The value wraps around at both ends of its range.

While `start` is low, the counter follows a 6-bit binary setpoint. The setpoint is converted to two BCD digits by the shift-and-add-3 method. The block also stores the last setpoint it loaded. It loads again only when the setpoint input differs from that stored value. As a result, after a counting run is stopped, the counter keeps the value it reached until the setpoint is actually moved. Counting, loading and reset all act on the single main clock.

Top module: `bcd_setpoint_counter`

## Requirements
- R1: A synchronous reset, sampled on a rising clock edge, sets both digits to 0, the prescaler to 0 and the stored setpoint to 0.
- R2: The step strobe is high in one clock out of eight. It is first high in the eighth clock after reset is released. The value can change while `start` is high only on a clock edge where the strobe is high.
- R3: Counting up with `count_up`=1, units below 9 increase by one. Units at 9 become 0 and tens increase by one.
- R4: Counting up from 63 gives 00.
- R5: Counting down with `count_up`=0, nonzero units decrease by one. Units at 0 with nonzero tens become 9, and tens decrease by one.
- R6: Counting down from 00 gives 63.
- R7: If `start` is low at a rising edge and `setpoint` differs from the stored setpoint, the digits take the BCD form of `setpoint` after that edge: tens = setpoint/10, units = setpoint%10. The stored setpoint takes the new value at the same edge.
- R8: If `start` is low and `setpoint` equals the stored setpoint, the digits hold, even when they differ from the setpoint.
- R9: While `start` is high, the `setpoint` input is ignored, and the digits hold on every edge where the strobe is low.
- R10: The outputs are always a valid BCD value in the range 00 to 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | 1: count on strobes; 0: follow setpoint |
| count_up | input | 1 | 1: count up; 0: count down |
| setpoint | input | 6 | Binary value loaded while idle |
| tens | output | 4 | BCD tens digit |
| units | output | 4 | BCD units digit |

## Verification
The hardest case to reach is R8: the counter must hold a value that differs from a setpoint that has not changed. The stimulus reaches it in three steps. It first loads a setpoint, then counts away from that value for many strobes with the setpoint held still, and then drops `start`. Random phases also count with the setpoint unchanged before stopping. The wrap cases are reached by loading 58 or 03 and counting across the end of the range in each direction.

// File: rtl/bcdc_pkg.sv
package bcdc_pkg;
  localparam int DIGIT_W = 4;
  localparam int NUM_DIGITS = 2;

  typedef logic [DIGIT_W-1:0] bcd_digit_t;

  typedef struct packed {
    bcd_digit_t tens;
    bcd_digit_t units;
  } bcd_pair_t;
endpackage

// File: rtl/bcdc_prescaler.sv
module bcdc_prescaler #(
  parameter int PRE_W = 3
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  logic [PRE_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + 1'b1;
  end

  // Strobe when every bit of the divider is one.
  assign tick = &div_q;
endmodule

// File: rtl/bcdc_bin2bcd.sv
module bcdc_bin2bcd #(
  parameter int BIN_W  = 6,
  parameter int DIGITS = 2
) (
  input  logic [BIN_W-1:0]    bin,
  output logic [4*DIGITS-1:0] bcd
);
  localparam int SR_W = BIN_W + 4 * DIGITS;

  logic [SR_W-1:0] sr;

  // Double-dabble: before each shift, add 3 to every digit of 5 or more.
  always_comb begin
    sr = '0;
    sr[BIN_W-1:0] = bin;
    for (int s = 0; s < BIN_W; s++) begin
      for (int d = 0; d < DIGITS; d++) begin
        if (sr[BIN_W+4*d +: 4] >= 4'd5)
          sr[BIN_W+4*d +: 4] = sr[BIN_W+4*d +: 4] + 4'd3;
      end
      sr = sr << 1;
    end
  end

  assign bcd = sr[SR_W-1:BIN_W];
endmodule

// File: rtl/bcdc_step.sv
module bcdc_step
  import bcdc_pkg::*;
#(
  parameter int MAX_VAL = 63
) (
  input  bcd_pair_t cur,
  input  logic      up,
  output bcd_pair_t nxt
);
  localparam bcd_digit_t TOP_T = bcd_digit_t'(MAX_VAL / 10);
  localparam bcd_digit_t TOP_U = bcd_digit_t'(MAX_VAL % 10);

  always_comb begin
    nxt = cur;
    if (up) begin
      if (cur.tens == TOP_T && cur.units == TOP_U) begin
        nxt.tens  = '0;
        nxt.units = '0;
      end else if (cur.units == 4'd9) begin
        nxt.units = '0;
        nxt.tens  = cur.tens + 4'd1;
      end else begin
        nxt.units = cur.units + 4'd1;
      end
    end else begin
      if (cur.units == 4'd0) begin
        if (cur.tens == 4'd0) begin
          nxt.tens  = TOP_T;
          nxt.units = TOP_U;
        end else begin
          nxt.tens  = cur.tens - 4'd1;
          nxt.units = 4'd9;
        end
      end else begin
        nxt.units = cur.units - 4'd1;
      end
    end
  end
endmodule

// File: rtl/bcd_setpoint_counter.sv
module bcd_setpoint_counter
  import bcdc_pkg::*;
#(
  parameter int PRE_W = 3,
  parameter int SET_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             count_up,
  input  logic [SET_W-1:0] setpoint,
  output logic [3:0]       tens,
  output logic [3:0]       units
);
  localparam int MAX_VAL = (1 << SET_W) - 1;

  logic                  tick;
  logic [4*NUM_DIGITS-1:0] set_bcd;
  bcd_pair_t             cnt_q;
  bcd_pair_t             step_nxt;
  logic [SET_W-1:0]      prev_q;

  bcdc_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  bcdc_bin2bcd #(.BIN_W(SET_W), .DIGITS(NUM_DIGITS)) u_conv (
    .bin (setpoint),
    .bcd (set_bcd)
  );

  bcdc_step #(.MAX_VAL(MAX_VAL)) u_step (
    .cur (cnt_q),
    .up  (count_up),
    .nxt (step_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      prev_q <= '0;
    end else if (start && tick) begin
      cnt_q <= step_nxt;
    end else if (!start && setpoint != prev_q) begin
      cnt_q  <= bcd_pair_t'(set_bcd);
      prev_q <= setpoint;
    end
  end

  assign tens  = cnt_q.tens;
  assign units = cnt_q.units;
endmodule

// File: rtl/bcd_setpoint_counter_chk.sv
module bcd_setpoint_counter_chk #(
  parameter int PRE_W = 3,
  parameter int SET_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             count_up,
  input logic [SET_W-1:0] setpoint,
  input logic [3:0]       tens,
  input logic [3:0]       units,
  input logic             tick
);
  localparam int MAX_VAL = (1 << SET_W) - 1;
  localparam logic [3:0] TOP_T = 4'(MAX_VAL / 10);
  localparam logic [3:0] TOP_U = 4'(MAX_VAL % 10);

  logic [PRE_W-1:0] gap_q;
  always_ff @(posedge clk) begin
    if (rst) gap_q <= '0;
    else     gap_q <= gap_q + 1'b1;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (tens == 4'd0 && units == 4'd0));

  p_tick_period_r2: assert property (@(posedge clk) disable iff (rst)
    tick |-> (gap_q == {PRE_W{1'b1}}));

  p_up_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (start && count_up && tick && tens == TOP_T && units == TOP_U)
      |=> (tens == 4'd0 && units == 4'd0));

  p_down_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (start && !count_up && tick && tens == 4'd0 && units == 4'd0)
      |=> (tens == TOP_T && units == TOP_U));

  p_hold_between_ticks_r9: assert property (@(posedge clk) disable iff (rst)
    (start && !tick) |=> ($stable(tens) && $stable(units)));

  p_valid_bcd_r10: assert property (@(posedge clk) disable iff (rst)
    (units <= 4'd9) && (tens < TOP_T || (tens == TOP_T && units <= TOP_U)));
endmodule

bind bcd_setpoint_counter bcd_setpoint_counter_chk #(
  .PRE_W (PRE_W),
  .SET_W (SET_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .count_up (count_up),
  .setpoint (setpoint),
  .tens     (tens),
  .units    (units),
  .tick     (tick)
);

// File: tb/bcd_setpoint_counter_test.sv
module bcd_setpoint_counter_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       start;
  logic       count_up;
  logic [5:0] setpoint;
  logic [3:0] tens;
  logic [3:0] units;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int m_val, m_prev, m_pre;
  string m_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_setpoint_counter uut (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .count_up (count_up),
    .setpoint (setpoint),
    .tens     (tens),
    .units    (units)
  );

  function automatic int step_val(int v, bit up);
    if (up) return (v == 63) ? 0 : v + 1;
    return (v == 0) ? 63 : v - 1;
  endfunction

  function automatic string step_tag(int v, bit up);
    if (up) return (v == 63) ? "R4" : "R3";
    return (v == 0) ? "R6" : "R5";
  endfunction

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  // One clock: drive on the falling edge, update the model at the rising edge, compare after it.
  task automatic cycle(bit r, bit s, bit up, int sp);
    bit tk;
    @(negedge clk);
    rst = r; start = s; count_up = up; setpoint = 6'(sp);
    @(posedge clk);
    tk = (m_pre == 7);
    m_pre = (m_pre + 1) % 8;
    if (r) begin
      m_val = 0; m_prev = 0; m_pre = 0; m_tag = "R1";
    end else if (s && tk) begin
      m_tag = {step_tag(m_val, up), "/R2"};
      m_val = step_val(m_val, up);
    end else if (!s && sp != m_prev) begin
      m_val = sp; m_prev = sp; m_tag = "R7";
    end else begin
      m_tag = s ? "R9/R2" : "R8";
    end
    #(CLK_PERIOD/4);
    check(m_tag, 10 * int'(tens) + int'(units), m_val);
    checks++;
    if (units > 4'd9 || (10 * int'(tens) + int'(units)) > 63) begin
      errors++;
      $display("FAIL R10: got tens=%0d units=%0d expected a BCD value 0..63", tens, units);
    end
  endtask

  initial begin
    int sp, s, up, tmp;
    tmp = $urandom(32'd20240611);
    m_val = 0; m_prev = 0; m_pre = 0;
    rst = 1; start = 0; count_up = 1; setpoint = 0;
    cycle(1, 0, 1, 0);
    cycle(1, 0, 1, 0);
    // R7: load 58, then count up through 59->60 carry (R3) and 63->00 wrap (R4)
    cycle(0, 0, 1, 58);
    for (int i = 0; i < 8 * 8; i++) cycle(0, 1, 1, 58);
    // R8: stop with setpoint unchanged, value must hold
    for (int i = 0; i < 10; i++) cycle(0, 0, 1, 58);
    // R9: running with a moving setpoint that must be ignored
    for (int i = 0; i < 24; i++) cycle(0, 1, 1, i);
    // Load 3, count down through 00->63 (R6) and 60->59 borrow (R5)
    cycle(0, 0, 0, 3);
    for (int i = 0; i < 8 * 9; i++) cycle(0, 1, 0, 3);
    cycle(0, 0, 0, 3);
    cycle(0, 0, 0, 0);
    // Random phases
    sp = 0;
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 9) == 0) sp = $urandom_range(0, 63);
      s  = ($urandom_range(0, 3) != 0);
      if ((i / 50) % 2 == 1) s = 0;
      up = ((i / 300) % 2 == 0);
      cycle(($urandom_range(0, 999) == 0), s[0], up[0], sp);
    end
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule